// File: doc/BRIEF.md
# Inverter Start-Up Pulse Sequencer

This block sits on the controller side of a three-phase inverter bridge with a brake switch. After power-up it runs a one-time start-up sequence, then hands the seven gate commands over to the normal PWM generator. All seven commands are active low: a low level turns a switch on.

The sequence has two phases. The first charges the high-side bootstrap supplies. It drives a train of short on-pulses on the three lower-switch commands together, and the number of pulses is set at the time of the start strobe. The second clears the power stage's latched fault output. It gives one on-pulse to the brake command, then one to the three lower commands, then one to the three upper commands. When the last upper pulse has ended, a ready flag rises. From then on the external PWM commands pass through with one register of delay.

Pulse width and the gap between pulses are parameters counted in clock cycles. The default gap is larger than the 2.2 µs that the bridge needs between the upper and lower switch of a leg.

Top module: `startup_pulse_seq`

## Requirements
- R1: After reset, every command output is high (off) and `ready` is low.
- R2: Before a start strobe, all commands stay high and `ready` stays low, whatever the PWM inputs do.
- R3: The bootstrap phase gives N on-pulses. Each pulse drives all three lower commands low together for exactly PULSE_CYC cycles, and each pulse is followed by exactly GAP_CYC cycles with the lower commands high. During the sequence the lower bus is always either all 0 or all 1.
- R4: N is the `pulse_count` value captured at the start strobe, clamped into the range [MIN_PULSES, MAX_PULSES] (10 to 500 by default).
- R5: The fault-clearing phase gives exactly one PULSE_CYC-long on-pulse to each group, in a fixed order. The brake goes first, then the three lower commands together, then the three upper commands together.
- R6: No upper and lower command of the same leg are ever low together during the sequence. Every on-pulse, across all groups, begins exactly GAP_CYC cycles after the previous pulse ended.
- R7: During the sequence the PWM inputs are ignored, and every command that is not being pulsed is held high.
- R8: `ready` rises exactly (N+3)·(PULSE_CYC+GAP_CYC)+1 clock edges after the edge that samples `start`. Once high, it stays high until reset.
- R9: While `ready` is high, each command output equals its PWM input as sampled on the previous clock edge.
- R10: A start strobe received while `ready` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only while idle |
| pulse_count | input | CNT_W | Requested number of bootstrap pulses |
| pwm_hi_n | input | 3 | External upper-switch commands, active low |
| pwm_lo_n | input | 3 | External lower-switch commands, active low |
| pwm_brk_n | input | 1 | External brake command, active low |
| cmd_hi_n | output | 3 | Upper-switch commands to the bridge, active low |
| cmd_lo_n | output | 3 | Lower-switch commands to the bridge, active low |
| cmd_brk_n | output | 1 | Brake command to the bridge, active low |
| ready | output | 1 | High once the sequence has finished and PWM passes through |

## Verification
The hardest cases to reach are the clamp boundaries: 0, 9, 10, 11, 500, 501 and the all-ones count. Each one needs a complete reset-and-run cycle, because the sequence runs only once. The bench therefore resets before every count it tries. It uses a small pulse width and gap, so that even the largest count finishes in a few thousand cycles. The PWM inputs are held all-on throughout every run, so any leak through to the outputs shows up as an extra pulse or a shoot-through sample. A monitor measures every low run and every gap, and the bench compares the counts and the ready latency against values it computes arithmetically.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOOT_ON,
    ST_BOOT_GAP,
    ST_CLR_ON,
    ST_CLR_GAP,
    ST_RUN
  } seq_state_t;

  // fault-clearing groups, in the order they are pulsed
  localparam int CLR_STEPS = 3;
  localparam int STEP_BRK  = 0;
  localparam int STEP_LO   = 1;
  localparam int STEP_HI   = 2;

endpackage

// File: rtl/seq_count_clamp.sv
module seq_count_clamp #(
  parameter int CNT_W      = 9,
  parameter int MIN_PULSES = 10,
  parameter int MAX_PULSES = 500
) (
  input  logic [CNT_W-1:0] raw,
  output logic [CNT_W-1:0] clamped
);
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(MIN_PULSES);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(MAX_PULSES);

  always_comb begin
    if (raw < LO_LIM)      clamped = LO_LIM;
    else if (raw > HI_LIM) clamped = HI_LIM;
    else                   clamped = raw;
  end
endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/startup_pulse_seq.sv
module startup_pulse_seq
  import startup_seq_pkg::*;
#(
  parameter int PULSE_CYC  = 2000,
  parameter int GAP_CYC    = 250,
  parameter int CNT_W      = 9,
  parameter int MIN_PULSES = 10,
  parameter int MAX_PULSES = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] pulse_count,
  input  logic [2:0]       pwm_hi_n,
  input  logic [2:0]       pwm_lo_n,
  input  logic             pwm_brk_n,
  output logic [2:0]       cmd_hi_n,
  output logic [2:0]       cmd_lo_n,
  output logic             cmd_brk_n,
  output logic             ready
);
  localparam int TMAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PW_LD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] GAP_LD = TW'(GAP_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d, n_clamped;
  logic [1:0]       step_q, step_d;
  logic             tmr_load, tmr_done;
  logic [TW-1:0]    tmr_val;

  seq_count_clamp #(
    .CNT_W(CNT_W), .MIN_PULSES(MIN_PULSES), .MAX_PULSES(MAX_PULSES)
  ) u_clamp (
    .raw(pulse_count), .clamped(n_clamped)
  );

  seq_step_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = PW_LD;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_BOOT_ON;
        rem_d    = n_clamped;
        tmr_load = 1'b1;
      end
      ST_BOOT_ON: if (tmr_done) begin
        state_d  = ST_BOOT_GAP;
        rem_d    = rem_q - 1'b1;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      ST_BOOT_GAP: if (tmr_done) begin
        tmr_load = 1'b1;
        if (rem_q == '0) begin
          state_d = ST_CLR_ON;
          step_d  = 2'(STEP_BRK);
        end else begin
          state_d = ST_BOOT_ON;
        end
      end
      ST_CLR_ON: if (tmr_done) begin
        state_d  = ST_CLR_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      ST_CLR_GAP: if (tmr_done) begin
        if (step_q == 2'(CLR_STEPS - 1)) begin
          state_d = ST_RUN;
        end else begin
          state_d  = ST_CLR_ON;
          step_d   = step_q + 1'b1;
          tmr_load = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      step_q  <= step_d;
    end
  end

  // registered command outputs, derived from the current state
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_hi_n  <= '1;
      cmd_lo_n  <= '1;
      cmd_brk_n <= 1'b1;
      ready     <= 1'b0;
    end else if (state_q == ST_RUN) begin
      cmd_hi_n  <= pwm_hi_n;
      cmd_lo_n  <= pwm_lo_n;
      cmd_brk_n <= pwm_brk_n;
      ready     <= 1'b1;
    end else begin
      cmd_lo_n  <= (state_q == ST_BOOT_ON ||
                    (state_q == ST_CLR_ON && step_q == 2'(STEP_LO))) ? 3'b000 : 3'b111;
      cmd_hi_n  <= (state_q == ST_CLR_ON && step_q == 2'(STEP_HI)) ? 3'b000 : 3'b111;
      cmd_brk_n <= !(state_q == ST_CLR_ON && step_q == 2'(STEP_BRK));
      ready     <= 1'b0;
    end
  end

  // R6: never both switches of one leg on while sequencing
  p_no_shoot_r6: assert property (@(posedge clk) disable iff (rst)
    !ready |-> ((~cmd_hi_n & ~cmd_lo_n) == 3'b000));

  // R3: lower commands move as one group during the sequence
  p_lo_group_r3: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (cmd_lo_n == 3'b000 || cmd_lo_n == 3'b111));

  // R2: idle state keeps every command off
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (cmd_hi_n == 3'b111 && cmd_lo_n == 3'b111 && cmd_brk_n && !ready));

  // R8: ready is sticky
  p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R9: pass-through with one register of delay
  p_pass_r9: assert property (@(posedge clk) disable iff (rst)
    ready |=> (cmd_lo_n == $past(pwm_lo_n) && cmd_hi_n == $past(pwm_hi_n)
               && cmd_brk_n == $past(pwm_brk_n)));

  // R7: brake never on together with a lower pulse during the sequence
  p_brk_alone_r7: assert property (@(posedge clk) disable iff (rst)
    (!ready && !cmd_brk_n) |-> (cmd_lo_n == 3'b111 && cmd_hi_n == 3'b111));

endmodule

// File: tb/startup_pulse_seq_tb.sv
module startup_pulse_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW    = 3;
  localparam int GAP   = 2;
  localparam int CW    = 9;
  localparam int NMIN  = 10;
  localparam int NMAX  = 500;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] pulse_count = '0;
  logic [2:0]    pwm_hi_n = '0, pwm_lo_n = '0;
  logic          pwm_brk_n = 1'b0;
  logic [2:0]    cmd_hi_n, cmd_lo_n;
  logic          cmd_brk_n, ready;

  startup_pulse_seq #(
    .PULSE_CYC(PW), .GAP_CYC(GAP), .CNT_W(CW),
    .MIN_PULSES(NMIN), .MAX_PULSES(NMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .pulse_count(pulse_count),
    .pwm_hi_n(pwm_hi_n), .pwm_lo_n(pwm_lo_n), .pwm_brk_n(pwm_brk_n),
    .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n), .cmd_brk_n(cmd_brk_n),
    .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sequence monitor, sampled at negedge
  bit mon_en = 0;
  int lo_run, hi_run, brk_run, lo_pulses, hi_pulses, brk_pulses;
  int last_rise, lo_last_fall, hi_fall, brk_fall;
  bit lo_prev, hi_prev, brk_prev;

  task automatic mon_clear();
    lo_run = 0; hi_run = 0; brk_run = 0;
    lo_pulses = 0; hi_pulses = 0; brk_pulses = 0;
    last_rise = -1; lo_last_fall = -1; hi_fall = -1; brk_fall = -1;
    lo_prev = 1; hi_prev = 1; brk_prev = 1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_en && !ready) begin
      // R3: lower bus uniform
      if (!(cmd_lo_n == 3'b000 || cmd_lo_n == 3'b111))
        chk(0, "R3 lo bus uniform", cmd_lo_n, 0);
      // R6: shoot-through
      if ((~cmd_hi_n & ~cmd_lo_n) != 3'b000)
        chk(0, "R6 shoot-through", {cmd_hi_n, cmd_lo_n}, 0);
      // falls: gap since previous rise (R6)
      if (lo_prev && !cmd_lo_n[0]) begin
        if (last_rise >= 0) chk(cyc - last_rise == GAP, "R6 gap before lo", cyc - last_rise, GAP);
        lo_last_fall = cyc;
      end
      if (hi_prev && !cmd_hi_n[0]) begin
        if (last_rise >= 0) chk(cyc - last_rise == GAP, "R6 gap before hi", cyc - last_rise, GAP);
        hi_fall = cyc;
      end
      if (brk_prev && !cmd_brk_n) begin
        if (last_rise >= 0) chk(cyc - last_rise == GAP, "R6 gap before brk", cyc - last_rise, GAP);
        brk_fall = cyc;
      end
      // rises: widths (R3, R5)
      if (!lo_prev && cmd_lo_n[0]) begin
        chk(lo_run == PW, "R3 lo width", lo_run, PW); lo_pulses++; last_rise = cyc; lo_run = 0;
      end
      if (!hi_prev && cmd_hi_n[0]) begin
        chk(hi_run == PW, "R5 hi width", hi_run, PW); hi_pulses++; last_rise = cyc; hi_run = 0;
      end
      if (!brk_prev && cmd_brk_n) begin
        chk(brk_run == PW, "R5 brk width", brk_run, PW); brk_pulses++; last_rise = cyc; brk_run = 0;
      end
      if (!cmd_lo_n[0]) lo_run++;
      if (!cmd_hi_n[0]) hi_run++;
      if (!cmd_brk_n)   brk_run++;
      lo_prev = cmd_lo_n[0]; hi_prev = cmd_hi_n[0]; brk_prev = cmd_brk_n;
    end
  end

  function automatic int clampn(input int n);
    return (n < NMIN) ? NMIN : (n > NMAX) ? NMAX : n;
  endfunction

  task automatic run_one(input int req_n);
    int nexp, lat, expl;
    nexp = clampn(req_n);
    @(negedge clk);
    rst = 1'b1; start = 0;
    pwm_hi_n = '0; pwm_lo_n = '0; pwm_brk_n = 0;   // all "on": must be ignored
    pulse_count = CW'(req_n);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd_hi_n == 3'b111 && cmd_lo_n == 3'b111 && cmd_brk_n && !ready, "R1 reset state",
        {ready, cmd_brk_n, cmd_hi_n, cmd_lo_n}, 8'h7f);
    for (int i = 0; i < 4; i++) @(negedge clk);
    // R2 idle ignores pwm
    chk(cmd_hi_n == 3'b111 && cmd_lo_n == 3'b111 && cmd_brk_n && !ready, "R2 idle quiet",
        {ready, cmd_brk_n, cmd_hi_n, cmd_lo_n}, 8'h7f);
    mon_clear();
    mon_en = 1;
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    pulse_count = '1;            // changes after capture must not matter
    lat = 0;
    while (!ready && cyc < WATCHDOG) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    mon_en = 0;
    expl = (nexp + 3) * (PW + GAP) + 1;
    chk(lat == expl, "R8 ready latency", lat, expl);
    chk(lo_pulses == nexp + 1, "R4 lower pulse count (clamped)", lo_pulses, nexp + 1);
    chk(brk_pulses == 1, "R5 brake pulses", brk_pulses, 1);
    chk(hi_pulses == 1, "R7 upper pulses with pwm held on", hi_pulses, 1);
    chk(brk_fall >= 0 && brk_fall < lo_last_fall, "R5 brake before clear lower", brk_fall, lo_last_fall);
    chk(lo_last_fall < hi_fall, "R5 lower before upper", lo_last_fall, hi_fall);
  endtask

  task automatic pass_sweep();
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      {pwm_brk_n, pwm_hi_n, pwm_lo_n} = 7'(v);
      @(negedge clk);
      chk({cmd_brk_n, cmd_hi_n, cmd_lo_n} == 7'(v) && ready, "R9 pass-through",
          {cmd_brk_n, cmd_hi_n, cmd_lo_n}, v);
    end
  endtask

  initial begin
    int counts[8] = '{0, 9, 10, 11, 37, 500, 501, 511};
    for (int k = 0; k < 8; k++) begin
      run_one(counts[k]);
      if (k == 0 || k == 7) pass_sweep();
    end
    // R10: start after ready ignored
    @(negedge clk);
    pwm_hi_n = 3'b101; pwm_lo_n = 3'b010; pwm_brk_n = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(ready && cmd_hi_n == 3'b101 && cmd_lo_n == 3'b010 && cmd_brk_n, "R10 start ignored",
          {ready, cmd_brk_n, cmd_hi_n, cmd_lo_n}, {1'b1, 1'b1, 3'b101, 3'b010});
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule